// File: doc/BRIEF.md
# Prescaled Single-Channel PWM with Register Control

This block produces one pulse-width-modulated output and a separate backlight-enable level. Both are controlled through a small byte-wide register file that a host reaches over a plain address, write-data, write-strobe and read-data port. Writes take effect on the clock edge that samples the strobe. Reads are combinational from the stored values.

A divider register holds two things: an output-enable flag in its top bit, and a 7-bit prescaler code N in its low bits. The prescaler divides the block clock by N+1 to make a tick. An 8-bit period counter advances once per tick, so one period lasts 256 ticks. The output is high while the counter is below the active duty level. The duty level is taken from its register only at a period boundary. The prescaler code is taken only while the output is disabled. To change the rate, the host first writes 0 to the divider register and then writes the new code with the enable bit set. The backlight-enable pin comes straight from its own one-bit register and is independent of the PWM.

The core is a two-state machine. In IDLE the counter and prescaler are held at zero, the output is low, and the active code and duty level follow their registers every cycle. The transition START moves IDLE to RUN on the first edge that sees the enable bit set. The transition STOP moves RUN to IDLE on the first edge that sees the enable bit clear. In RUN the prescaler and counter advance, and the output follows the compare.

Top module: `prescaled_pwm`

## Requirements
- R1: A synchronous active-low reset clears every register to 0, so `pwm_out` and `backlight_en` are low and all three register reads return 0x00.
- R2: Address 0x4B is the divider register. Bit 7 is the output enable and bits 6:0 are the prescaler code N. A read returns the full written byte.
- R3: While enabled, one PWM period lasts 256 × (N+1) clock cycles, measured from one rising edge of `pwm_out` to the next.
- R4: Address 0x4E holds the 8-bit duty level L. Each period begins with `pwm_out` high for L × (N+1) cycles, followed by low for the rest of the period. L = 0 keeps the output low. L = 255 leaves it low for one tick per period.
- R5: While the enable bit is 0, `pwm_out` is low and the period counter is held at zero. After the enabling write, `pwm_out` is still low in the following cycle and becomes high one cycle later (when L > 0), starting a fresh full-length high phase.
- R6: A prescaler code written while the output is running has no effect on the period, although it reads back at once. It takes effect after a write that clears the enable bit, followed by an enabling write.
- R7: A duty level written in the middle of a period does not change that period. The new level applies from the next period.
- R8: Address 0x51 is the backlight register. Bit 0 of a write drives `backlight_en`. A read returns 0x00 or 0x01.
- R9: Writes to any address other than 0x4B, 0x4E and 0x51 change nothing. Reads of such addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the base clock of the prescaler |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 1 | PWM output |
| backlight_en | output | 1 | Backlight enable level |

## Verification
Two conditions are the hardest to reach from the ports. The first is a duty write that lands in the middle of a live high phase. The second is a prescaler code written while the output runs. The bench meets the first by timing the duty write to a fixed number of cycles after an observed rising edge of `pwm_out`, then measuring that pulse and the next one. For the second, it rewrites the divider register with the enable bit still set and a different code, measures an unchanged period, and then goes through the clear-then-enable sequence to show that the new rate applies.

// File: rtl/prescaled_pwm_pkg.sv
package prescaled_pwm_pkg;

    localparam int REG_W  = 8;
    localparam int CODE_W = 7;
    localparam int CNT_W  = 8;

    localparam logic [REG_W-1:0] ADDR_DIVIDER   = 8'h4B;
    localparam logic [REG_W-1:0] ADDR_DUTY      = 8'h4E;
    localparam logic [REG_W-1:0] ADDR_BACKLIGHT = 8'h51;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pwm_state_e;

endpackage

// File: rtl/prescaled_pwm_regs.sv
module prescaled_pwm_regs
    import prescaled_pwm_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int CODE_BITS = CODE_W,
    parameter logic [DATA_W-1:0] A_DIV = ADDR_DIVIDER,
    parameter logic [DATA_W-1:0] A_DUTY = ADDR_DUTY,
    parameter logic [DATA_W-1:0] A_BL = ADDR_BACKLIGHT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic                 we_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 run_en_o,
    output logic [CODE_BITS-1:0] code_o,
    output logic [DATA_W-1:0]    level_o,
    output logic                 bl_o
);

    localparam int EN_BIT = DATA_W - 1;

    logic [DATA_W-1:0] div_q;
    logic [DATA_W-1:0] duty_q;
    logic              bl_q;

    logic hit_div, hit_duty, hit_bl;

    always_comb begin
        hit_div  = (addr_i == A_DIV);
        hit_duty = (addr_i == A_DUTY);
        hit_bl   = (addr_i == A_BL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            duty_q <= '0;
            bl_q   <= 1'b0;
        end else if (we_i) begin
            if (hit_div)  div_q  <= wdata_i;
            if (hit_duty) duty_q <= wdata_i;
            if (hit_bl)   bl_q   <= wdata_i[0];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit_div)       rdata_o = div_q;
        else if (hit_duty) rdata_o = duty_q;
        else if (hit_bl)   rdata_o = {{(DATA_W-1){1'b0}}, bl_q};
    end

    always_comb begin
        run_en_o = div_q[EN_BIT];
        code_o   = div_q[CODE_BITS-1:0];
        level_o  = duty_q;
        bl_o     = bl_q;
    end

    AST_BL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && hit_bl) |=> (bl_q == $past(wdata_i[0])));  // R8

    AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !hit_div && !hit_duty && !hit_bl) |=>
        ($stable(div_q) && $stable(duty_q) && $stable(bl_q)));  // R9

    AST_DIV_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && hit_div) |=> (div_q == $past(wdata_i)));  // R2

endmodule

// File: rtl/prescaled_pwm_prescaler.sv
module prescaled_pwm_prescaler #(
    parameter int CODE_BITS = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  logic [CODE_BITS-1:0] code_i,
    output logic                 tick_o
);

    logic [CODE_BITS-1:0] div_q;
    logic                 at_end;

    always_comb begin
        at_end = (div_q == code_i);
        tick_o = run_i && at_end;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       div_q <= '0;
        else if (!run_i)  div_q <= '0;
        else if (at_end)  div_q <= '0;
        else              div_q <= div_q + 1'b1;
    end

    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (div_q <= code_i));  // R3

    AST_DIV_HELD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (div_q == '0));  // R5

endmodule

// File: rtl/prescaled_pwm_core.sv
module prescaled_pwm_core
    import prescaled_pwm_pkg::*;
#(
    parameter int CODE_BITS = CODE_W,
    parameter int CNT_BITS  = CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic [CODE_BITS-1:0] code_i,
    input  logic [CNT_BITS-1:0]  level_i,
    output logic                 pwm_o
);

    localparam logic [CNT_BITS-1:0] CNT_LAST = '1;

    pwm_state_e           state_q, state_d;
    logic [CODE_BITS-1:0] code_act;
    logic [CNT_BITS-1:0]  level_act;
    logic [CNT_BITS-1:0]  cnt_q;
    logic                 running;
    logic                 tick;
    logic                 wrap;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en_i)  state_d = ST_RUN;
            ST_RUN:  if (!en_i) state_d = ST_IDLE;
            default:            state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        running = (state_q == ST_RUN) && en_i;
        wrap    = tick && (cnt_q == CNT_LAST);
    end

    prescaled_pwm_prescaler #(
        .CODE_BITS(CODE_BITS)
    ) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .code_i (code_act),
        .tick_o (tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            code_act  <= '0;
            level_act <= '0;
        end else if (!running) begin
            cnt_q     <= '0;
            code_act  <= code_i;
            level_act <= level_i;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
            if (wrap) level_act <= level_i;
        end
    end

    always_comb begin
        pwm_o = running && (cnt_q < level_act);
    end

    AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en_i) |=> $stable(code_act));  // R6

    AST_LEVEL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en_i && !wrap) |=> $stable(level_act));  // R7

    AST_CNT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0));  // R5

    AST_CNT_STEPS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick) |=> $stable(cnt_q));  // R3

endmodule

// File: rtl/prescaled_pwm.sv
module prescaled_pwm
    import prescaled_pwm_pkg::*;
#(
    parameter int DATA_W    = REG_W,
    parameter int CODE_BITS = CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out,
    output logic              backlight_en
);

    logic                 run_en;
    logic [CODE_BITS-1:0] code;
    logic [DATA_W-1:0]    level;

    prescaled_pwm_regs #(
        .DATA_W    (DATA_W),
        .CODE_BITS (CODE_BITS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .we_i     (bus_we),
        .rdata_o  (bus_rdata),
        .run_en_o (run_en),
        .code_o   (code),
        .level_o  (level),
        .bl_o     (backlight_en)
    );

    prescaled_pwm_core #(
        .CODE_BITS (CODE_BITS),
        .CNT_BITS  (DATA_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (run_en),
        .code_i  (code),
        .level_i (level),
        .pwm_o   (pwm_out)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!pwm_out && !backlight_en));  // R1

endmodule

// File: tb/prescaled_pwm_tb.sv
module prescaled_pwm_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       pwm_out;
    logic       backlight_en;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    prescaled_pwm u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_we       (bus_we),
        .bus_rdata    (bus_rdata),
        .pwm_out      (pwm_out),
        .backlight_en (backlight_en)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    // Finds a rising edge of pwm_out, then measures that pulse's high time and
    // the cycles up to the next rising edge. Optionally writes mid-pulse.
    task automatic measure(input int wr_at, input logic [7:0] wa, input logic [7:0] wd,
                           output int hi, output int per);
        logic prev;
        logic in_hi;
        bit   found;
        hi = 0; per = 0; found = 0;
        @(negedge clk);
        prev = pwm_out;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (pwm_out && !prev) begin found = 1; break; end
            prev = pwm_out;
        end
        if (!found) begin
            hi = -1; per = -1;
            return;
        end
        in_hi = 1'b1;
        prev = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            if (in_hi && pwm_out) hi++;
            else in_hi = 1'b0;
            per++;
            if (per == wr_at) begin
                bus_addr = wa; bus_wdata = wd; bus_we = 1'b1;
            end else begin
                bus_we = 1'b0;
            end
            @(negedge clk);
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
        bus_we = 1'b0;
    endtask

    task automatic t_reset;
        int v;
        check("R1 pwm_out", int'(pwm_out), 0);
        check("R1 backlight_en", int'(backlight_en), 0);
        rd(8'h4B, v); check("R1 divider read", v, 0);
        rd(8'h4E, v); check("R1 duty read", v, 0);
        rd(8'h51, v); check("R1 backlight read", v, 0);
    endtask

    task automatic t_backlight;
        int v;
        wr(8'h51, 8'hFF);
        check("R8 backlight_en set", int'(backlight_en), 1);
        rd(8'h51, v); check("R8 backlight read", v, 1);
        check("R8 pwm unaffected", int'(pwm_out), 0);
        wr(8'h51, 8'hFE);
        check("R8 backlight_en clear", int'(backlight_en), 0);
    endtask

    task automatic t_stray;
        int v;
        wr(8'h4C, 8'hFF);
        wr(8'h50, 8'hFF);
        wr(8'h00, 8'h81);
        rd(8'h4C, v); check("R9 stray read 4C", v, 0);
        rd(8'h4B, v); check("R9 divider untouched", v, 0);
        rd(8'h4E, v); check("R9 duty untouched", v, 0);
        rd(8'h51, v); check("R9 backlight untouched", v, 0);
        check("R9 backlight pin", int'(backlight_en), 0);
    endtask

    task automatic t_disabled_hold;
        int v, hi;
        wr(8'h4E, 8'h40);
        wr(8'h4B, 8'h01);
        rd(8'h4B, v); check("R2 divider readback", v, 8'h01);
        count_high(600, hi);
        check("R5 low while disabled", hi, 0);
    endtask

    task automatic t_enable_and_run;
        int hi, per;
        wr(8'h4B, 8'h81);
        check("R5 low cycle after enable", int'(pwm_out), 0);
        @(negedge clk);
        check("R5 high second cycle", int'(pwm_out), 1);
        measure(0, 8'h00, 8'h00, hi, per);
        check("R4 high time L=64 N=1", hi, 128);
        check("R3 period N=1", per, 512);
    endtask

    task automatic t_duty_latch;
        int hi, per;
        measure(10, 8'h4E, 8'hC0, hi, per);
        check("R7 current pulse unchanged", hi, 128);
        check("R7 period unchanged", per, 512);
        measure(0, 8'h00, 8'h00, hi, per);
        check("R7 next pulse uses new level", hi, 384);
    endtask

    task automatic t_disable;
        int hi;
        wr(8'h4B, 8'h00);
        check("R5 low right after disable", int'(pwm_out), 0);
        count_high(300, hi);
        check("R5 stays low disabled", hi, 0);
    endtask

    task automatic t_full_and_zero;
        int hi, per;
        wr(8'h4E, 8'hFF);
        wr(8'h4B, 8'h80);
        measure(0, 8'h00, 8'h00, hi, per);
        check("R4 L=255 high", hi, 255);
        check("R3 period N=0", per, 256);
        wr(8'h4E, 8'h00);
        count_high(300, hi);
        count_high(600, hi);
        check("R4 L=0 constant low", hi, 0);
    endtask

    task automatic t_code_change;
        int v, hi, per;
        wr(8'h4E, 8'h80);
        count_high(300, hi);
        measure(0, 8'h00, 8'h00, hi, per);
        check("R4 L=128 N=0 high", hi, 128);
        wr(8'h4B, 8'h83);
        rd(8'h4B, v); check("R2 running readback", v, 8'h83);
        measure(0, 8'h00, 8'h00, hi, per);
        check("R6 period held while running", per, 256);
        wr(8'h4B, 8'h00);
        wr(8'h4B, 8'h83);
        measure(0, 8'h00, 8'h00, hi, per);
        check("R6 new period after re-enable", per, 1024);
        check("R6 new high time", hi, 512);
    endtask

    task automatic t_reset_midrun;
        int v;
        wr(8'h51, 8'h01);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 pwm low in reset", int'(pwm_out), 0);
        check("R1 backlight low in reset", int'(backlight_en), 0);
        rst_n = 1'b1;
        rd(8'h4B, v); check("R1 divider cleared", v, 0);
        rd(8'h4E, v); check("R1 duty cleared", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_backlight();
        t_stray();
        t_disabled_hold();
        t_enable_and_run();
        t_duty_latch();
        t_disable();
        t_full_and_zero();
        t_code_change();
        t_reset_midrun();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule